// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

This block is a synchronous memory with two independent ports that share one clock. Either port can read or write any word in a given cycle. Each port has its own clock-enable, write-enable, address, write data and read register. Read data appears one clock edge after the address is presented.

A parameter on each port selects what that port's read register shows in a cycle where the port writes. In read-first mode it shows the word that was stored before the write. In write-first mode it shows the data being written. In no-change mode it keeps its previous value. The two ports may use different modes within the same memory.

Each port also has a synchronous output clear that zeroes its read register without blocking a write in the same cycle. A chip-level synchronous active-low reset zeroes both read registers and leaves the stored words untouched. Same-address conflicts between the ports follow a fixed rule: port A wins when both ports write, and a port that reads while the other port writes sees the old word.

Top module: `dpram_dual_mode`

## Requirements
- R1: A port in read-first mode (mode code 0) that writes while enabled loads its read register with the word held at that address before the write, and the new data is stored.
- R2: A port in write-first mode (mode code 1) that writes while enabled loads its read register with its own write data in the same edge, and that data is stored.
- R3: A port in no-change mode (mode code 2) that writes while enabled keeps its read register unchanged, and the data is stored. On cycles without a write, it reads normally.
- R4: While a port's enable is low, that port writes nothing to memory and its read register holds, whatever its write-enable says.
- R5: When a port is enabled with its output clear high, its read register becomes zero on that edge, and a write requested in the same cycle is still stored.
- R6: The two ports of one memory can be built with different modes, and each port follows only its own mode.
- R7: If both ports write the same address in the same cycle, the stored word is port A's data.
- R8: If one port writes an address while the other port reads that address in the same cycle, the reading port returns the contents from before the write.
- R9: A read on an enabled port without a write or clear places the addressed word on that port's read data exactly one clock edge later.
- R10: While rst_n is low at a clock edge, both read registers become zero. Memory contents are kept.
- R11: The default geometry is 1024 words of 16 bits with a 10-bit address per port, and the highest address (1023) can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of both read registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_orst | input | 1 | Port A synchronous read-register clear |
| a_addr | input | ADDR_W (10) | Port A word address |
| a_wdata | input | WIDTH (16) | Port A write data |
| a_rdata | output | WIDTH (16) | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_orst | input | 1 | Port B synchronous read-register clear |
| b_addr | input | ADDR_W (10) | Port B word address |
| b_wdata | input | WIDTH (16) | Port B write data |
| b_rdata | output | WIDTH (16) | Port B registered read data |

## Verification
The hardest cases to reach from the ports are same-cycle conflicts. These include both ports writing one word, one port writing a word the other is reading, and an output clear landing on a write cycle. In a large address space, random stimulus almost never produces them. The random phase therefore confines most addresses to eight words, so that conflicts and clears over writes happen on a large share of cycles. A shadow array plus a per-mode output model predicts every read register on every cycle. Two instances with different mode pairings receive the same stimulus, so that all three modes are seen writing against each other.

// File: rtl/dpram_pkg.sv
// Shared types for the dual-port RAM.
// Assumes: the mode codes are also used by the bench and the brief.
package dpram_pkg;

    // Read-register behaviour on a write cycle
    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wr_mode_e;

endpackage

// File: rtl/dpram_store.sv
// Storage array with two write ports and two asynchronous read taps.
// Port A's write is applied after port B's, so port A wins a same-address write.
// Read taps show the contents before the coming edge, so a reader sees old data.
// Assumes: the write strobes are already qualified by the port enables.
module dpram_store #(
    parameter int DEPTH  = 1024,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WIDTH-1:0]  a_wdata,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WIDTH-1:0]  b_wdata,
    output logic [WIDTH-1:0]  a_old,
    output logic [WIDTH-1:0]  b_old
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Write both ports; the later assignment from port A takes priority
    always_ff @(posedge clk) begin
        if (b_wr) mem[b_addr] <= b_wdata;
        if (a_wr) mem[a_addr] <= a_wdata;
    end

    // Pre-edge contents for each port's read register
    always_comb begin
        a_old = mem[a_addr];
        b_old = mem[b_addr];
    end

    // Collision rule: port A's data is stored
    p_a_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && b_wr && a_addr == b_addr) |=> (mem[$past(a_addr)] == $past(a_wdata)));

    // A lone write from port B lands in memory
    p_b_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && !(a_wr && a_addr == b_addr)) |=> (mem[$past(b_addr)] == $past(b_wdata)));

endmodule

// File: rtl/dpram_outreg.sv
// Read register for one port. MODE picks what it loads on a write cycle.
// Clear and chip reset both force zero. Reset always acts; clear acts only when enabled.
// Assumes: old_word is the addressed word as held before the coming edge.
module dpram_outreg #(
    parameter int                 WIDTH = 16,
    parameter dpram_pkg::wr_mode_e MODE  = dpram_pkg::WM_READ_FIRST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic             orst,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] old_word,
    output logic [WIDTH-1:0] rdata
);

    logic             load;
    logic [WIDTH-1:0] load_val;

    // Per-mode choice of whether to load, and with what
    generate
        if (MODE == dpram_pkg::WM_WRITE_FIRST) begin : g_wf
            assign load     = 1'b1;
            assign load_val = we ? wdata : old_word;
        end else if (MODE == dpram_pkg::WM_NO_CHANGE) begin : g_nc
            assign load     = !we;
            assign load_val = old_word;
        end else begin : g_rf
            assign load     = 1'b1;
            assign load_val = old_word;
        end
    endgenerate

    // Register update: reset, then clear, then the mode's load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en) begin
            if (orst)      rdata <= '0;
            else if (load) rdata <= load_val;
        end
    end

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && orst) |=> (rdata == '0));

    p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !orst && !we) |=> (rdata == $past(old_word)));

    generate
        if (MODE == dpram_pkg::WM_WRITE_FIRST) begin : g_chk_wf
            p_echo_wdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !orst) |=> (rdata == $past(wdata)));
        end else if (MODE == dpram_pkg::WM_NO_CHANGE) begin : g_chk_nc
            p_hold_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !orst) |=> $stable(rdata));
        end else begin : g_chk_rf
            p_old_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we && !orst) |=> (rdata == $past(old_word)));
        end
    endgenerate

endmodule

// File: rtl/dpram_dual_mode.sv
// Top of the dual-port RAM. It gates each port's write with its enable,
// then instantiates the shared array and one read register per port.
// Assumes: both ports use clk; the memory is not cleared by rst_n.
module dpram_dual_mode #(
    parameter int                  DEPTH  = 1024,
    parameter int                  WIDTH  = 16,
    parameter dpram_pkg::wr_mode_e MODE_A = dpram_pkg::WM_READ_FIRST,
    parameter dpram_pkg::wr_mode_e MODE_B = dpram_pkg::WM_WRITE_FIRST,
    localparam int                 ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_orst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WIDTH-1:0]  a_wdata,
    output logic [WIDTH-1:0]  a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_orst,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WIDTH-1:0]  b_wdata,
    output logic [WIDTH-1:0]  b_rdata
);

    logic             a_wr, b_wr;
    logic [WIDTH-1:0] a_old, b_old;

    // A write happens only on an enabled port
    always_comb begin
        a_wr = a_en && a_we;
        b_wr = b_en && b_we;
    end

    dpram_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_old(a_old), .b_old(b_old)
    );

    dpram_outreg #(.WIDTH(WIDTH), .MODE(MODE_A)) u_out_a (
        .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we), .orst(a_orst),
        .wdata(a_wdata), .old_word(a_old), .rdata(a_rdata)
    );

    dpram_outreg #(.WIDTH(WIDTH), .MODE(MODE_B)) u_out_b (
        .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .orst(b_orst),
        .wdata(b_wdata), .old_word(b_old), .rdata(b_rdata)
    );

endmodule

// File: tb/dpram_dual_mode_tb.sv
`timescale 1ns/1ps
// Bench: u_dut (A read-first, B no-change) and u_dut2 (A write-first,
// B read-first) share one stimulus stream. A shadow array and a per-mode
// output model predict all four read registers on every cycle.
module dpram_dual_mode_tb;
    import dpram_pkg::*;

    localparam int AW = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic          a_en, a_we, a_orst, b_en, b_we, b_orst;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata;
    logic [DW-1:0] a1, b1, a2, b2;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] sh [1024];
    logic [DW-1:0] ea1, eb1, ea2, eb2;

    always #2 clk = ~clk;   // 250 MHz

    dpram_dual_mode #(.MODE_A(WM_READ_FIRST), .MODE_B(WM_NO_CHANGE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_orst(a_orst), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a1),
        .b_en(b_en), .b_we(b_we), .b_orst(b_orst), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b1)
    );

    dpram_dual_mode #(.MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) u_dut2 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_orst(a_orst), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a2),
        .b_en(b_en), .b_we(b_we), .b_orst(b_orst), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b2)
    );

    typedef struct packed {
        logic          aen, awe, aorst;
        logic [AW-1:0] aad;
        logic [DW-1:0] awd;
        logic          ben, bwe, borst;
        logic [AW-1:0] bad;
        logic [DW-1:0] bwd;
        logic [DW-1:0] xa, xb;   // expected u_dut outputs after the edge
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0,1'b0,1'b0,10'd5,16'h0000, 1'b1,1'b1,1'b0,10'd5,16'hAAAA, 16'h0000,16'h0000},
        '{1'b1,1'b0,1'b0,10'd5,16'h0000, 1'b1,1'b1,1'b0,10'd6,16'hBBBB, 16'hAAAA,16'h0000},
        '{1'b1,1'b1,1'b0,10'd5,16'h1234, 1'b1,1'b0,1'b0,10'd5,16'h0000, 16'hAAAA,16'hAAAA},
        '{1'b1,1'b0,1'b0,10'd6,16'h0000, 1'b1,1'b0,1'b0,10'd5,16'h0000, 16'hBBBB,16'h1234},
        '{1'b1,1'b1,1'b0,10'd6,16'h5678, 1'b1,1'b1,1'b0,10'd6,16'h9ABC, 16'hBBBB,16'h1234},
        '{1'b1,1'b0,1'b1,10'd6,16'h0000, 1'b1,1'b0,1'b0,10'd6,16'h0000, 16'h0000,16'h5678},
        '{1'b0,1'b1,1'b0,10'd5,16'hFFFF, 1'b1,1'b1,1'b1,10'd7,16'h0F0F, 16'h0000,16'h0000},
        '{1'b1,1'b0,1'b0,10'd5,16'h0000, 1'b1,1'b0,1'b0,10'd7,16'h0000, 16'h1234,16'h0F0F}
    };

    // Requirement tag for one table vector
    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3";
            1: return "R9";
            2: return "R8";
            3: return "R9";
            4: return "R7";
            5: return "R5";
            6: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Requirement a port's result depends on this cycle
    function automatic string tag_of(input wr_mode_e m, input logic rn, en, we, orst,
                                     input logic [AW-1:0] ad, input logic owr,
                                     input logic [AW-1:0] oad);
        if (!rn)   return "R10";
        if (!en)   return "R4";
        if (orst)  return "R5";
        if (we)    return (m == WM_READ_FIRST) ? "R1" : (m == WM_WRITE_FIRST) ? "R2" : "R3";
        if (owr && oad == ad) return "R8";
        return "R9";
    endfunction

    // Next read-register value for one port under a given mode
    function automatic logic [DW-1:0] next_out(input wr_mode_e m, input logic [DW-1:0] cur,
                                               input logic rn, en, we, orst,
                                               input logic [DW-1:0] wd, old);
        if (!rn)  return '0;
        if (!en)  return cur;
        if (orst) return '0;
        if (we) begin
            if (m == WM_WRITE_FIRST) return wd;
            if (m == WM_NO_CHANGE)   return cur;
        end
        return old;
    endfunction

    task automatic check(input logic [DW-1:0] act, exp, input string tag, input string what);
        if ($isunknown(exp)) return;
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model at the edge, compare after it
    task automatic step(input logic aen, awe, aorst, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                        input logic ben, bwe, borst, input logic [AW-1:0] bad, input logic [DW-1:0] bwd);
        logic [DW-1:0] oa, ob;
        string ta1, tb1, ta2, tb2;
        @(negedge clk);
        a_en = aen; a_we = awe; a_orst = aorst; a_addr = aad; a_wdata = awd;
        b_en = ben; b_we = bwe; b_orst = borst; b_addr = bad; b_wdata = bwd;
        @(posedge clk);
        oa = sh[aad];
        ob = sh[bad];
        ta1 = tag_of(WM_READ_FIRST,  rst_n, aen, awe, aorst, aad, ben && bwe, bad);
        tb1 = tag_of(WM_NO_CHANGE,   rst_n, ben, bwe, borst, bad, aen && awe, aad);
        ta2 = tag_of(WM_WRITE_FIRST, rst_n, aen, awe, aorst, aad, ben && bwe, bad);
        tb2 = tag_of(WM_READ_FIRST,  rst_n, ben, bwe, borst, bad, aen && awe, aad);
        ea1 = next_out(WM_READ_FIRST,  ea1, rst_n, aen, awe, aorst, awd, oa);
        eb1 = next_out(WM_NO_CHANGE,   eb1, rst_n, ben, bwe, borst, bwd, ob);
        ea2 = next_out(WM_WRITE_FIRST, ea2, rst_n, aen, awe, aorst, awd, oa);
        eb2 = next_out(WM_READ_FIRST,  eb2, rst_n, ben, bwe, borst, bwd, ob);
        if (ben && bwe) sh[bad] = bwd;
        if (aen && awe) sh[aad] = awd;   // R7: port A applied last
        #1;
        check(a1, ea1, ta1, "u_dut A");
        check(b1, eb1, tb1, "u_dut B");
        check(a2, ea2, ta2, "u_dut2 A");
        check(b2, eb2, tb2, "u_dut2 B");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) sh[i] = 'x;
        ea1 = '0; eb1 = '0; ea2 = '0; eb2 = '0;
        a_en = 0; a_we = 0; a_orst = 0; a_addr = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_orst = 0; b_addr = '0; b_wdata = '0;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(0,0,0,0,0, 0,0,0,0,0);
        // R10: reset state
        check(a1, 16'h0, "R10", "reset u_dut A");
        check(b1, 16'h0, "R10", "reset u_dut B");
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 8; i++) begin
            step(VECS[i].aen, VECS[i].awe, VECS[i].aorst, VECS[i].aad, VECS[i].awd,
                 VECS[i].ben, VECS[i].bwe, VECS[i].borst, VECS[i].bad, VECS[i].bwd);
            check(a1, VECS[i].xa, vec_tag(i), "table A");
            check(b1, VECS[i].xb, vec_tag(i), "table B");
        end

        // R11: top address of the default geometry
        step(1,1,0,10'd1023,16'hC3C3, 0,0,0,0,0);
        step(0,0,0,0,0, 1,0,0,10'd1023,0);
        check(b1, 16'hC3C3, "R11", "addr 1023 readback");

        // R7: simultaneous write to one word, port A wins
        step(1,1,0,10'd9,16'h1111, 1,1,0,10'd9,16'h2222);
        step(1,0,0,10'd9,0, 0,0,0,0,0);
        check(a1, 16'h1111, "R7", "collision winner");

        // R6: same write, read-first port gives old, write-first port gives new
        step(1,1,0,10'd9,16'h4444, 0,0,0,0,0);
        check(a1, 16'h1111, "R6", "read-first port A");
        check(a2, 16'h4444, "R6", "write-first port A");

        // R5: clear over a write still stores the data
        step(0,0,0,0,0, 1,1,1,10'd12,16'h7777);
        check(b1, 16'h0000, "R5", "clear on write");
        step(0,0,0,0,0, 1,0,0,10'd12,0);
        check(b1, 16'h7777, "R5", "write under clear stored");

        // R10: mid-run reset clears outputs, memory kept
        rst_n = 1'b0;
        step(1,0,0,10'd9,0, 1,0,0,10'd12,0);
        check(a1, 16'h0, "R10", "mid reset A");
        rst_n = 1'b1;
        step(1,0,0,10'd9,0, 0,0,0,0,0);
        check(a1, 16'h4444, "R10", "memory kept over reset");

        // Random mix focused on eight words to force conflicts
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] ra, rb;
            ra = ($urandom_range(0, 9) == 0) ? AW'($urandom_range(0, 1023)) : AW'($urandom_range(0, 7));
            rb = ($urandom_range(0, 9) == 0) ? AW'($urandom_range(0, 1023)) : AW'($urandom_range(0, 7));
            rst_n = ($urandom_range(0, 99) != 0);
            step(($urandom_range(0, 3) != 0), $urandom_range(0, 1), ($urandom_range(0, 7) == 0), ra, DW'($urandom),
                 ($urandom_range(0, 3) != 0), $urandom_range(0, 1), ($urandom_range(0, 7) == 0), rb, DW'($urandom));
        end
        rst_n = 1'b1;
        finish_run();
    end

endmodule